// File: doc/BRIEF.md
# Duplicated-Instruction Result Checker

This block watches the four issue slots of a wide-issue integer datapath and looks for soft errors by comparing each protected instruction with its redundant copy. Every slot reports a result with four flags: valid, a protection mark, a copy flag that separates the original from its redundant twin, and a kind bit that separates register values from memory addresses. Protected results go into one of two pairing queues, one for register values and one for load/store addresses. Unprotected results are ignored.

The compiler may place a copy in the same cycle on another free slot, or in any later cycle, including an inserted padding cycle. For this reason the block does not compare in lockstep. An original and its copy carry the same small sequence tag. Whichever of the two arrives first waits in its queue. When the partner with the same tag and the opposite role arrives, the two values are compared and the entry is freed. A mismatch raises a sticky error flag and records which queue and which tag failed first. A result that can neither pair nor find a free entry is dropped, and that queue's overflow flag is raised.

Top module: `dup_result_checker`

## Requirements
- R1: A result with slot_vld=1 and slot_dup=1 is routed by its slot_kind bit: 0 selects the value queue and 1 selects the address queue. The two queues never pair with each other.
- R2: When a result meets a held entry with the same tag and the opposite slot_copy role, the two data words are compared. Equal words leave err_flag low. Different words set err_flag at the next rising clock edge.
- R3: Pairing works with any delay between the two halves and in either order. A copy that arrives before its original is held until the original comes.
- R4: Pairing matches on equal tags, not on arrival order. Several open tags may be pending at once.
- R5: A result with slot_dup=0 is neither queued nor compared, even when its tag matches a pending entry.
- R6: err_flag stays set until clr_err is asserted. A clear cycle drops all flags, except that a mismatch detected in that same cycle sets err_flag again.
- R7: err_queue (0 = value, 1 = address) and err_tag hold the source of the first mismatch until the next clear. Among mismatches in the same cycle, the value queue wins over the address queue, and within a queue the lowest slot index wins.
- R8: Each queue holds 8 unpaired entries. A pairing frees its entry. A result that neither pairs nor finds space is dropped and sets that queue's overflow flag (ovf_value or ovf_addr). The flag stays set until clr_err or reset.
- R9: When several slots push in one cycle, they are handled in slot-index order. Two halves of a pair issued in the same cycle therefore pair with each other.
- R10: While rst_n is low at a rising edge, both queues empty and all flags and status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld | input | 4 | Per-slot result valid |
| slot_dup | input | 4 | Per-slot protection mark (1 = duplicated) |
| slot_copy | input | 4 | Per-slot role (0 = original, 1 = redundant copy) |
| slot_kind | input | 4 | Per-slot result kind (0 = register value, 1 = address) |
| slot_tag | input | 16 | Per-slot sequence tag, 4 bits per slot, slot 0 in the low bits |
| slot_data | input | 128 | Per-slot result, 32 bits per slot, slot 0 in the low bits |
| clr_err | input | 1 | Clears error, status and overflow flags |
| err_flag | output | 1 | Sticky mismatch indication |
| err_queue | output | 1 | Queue of the first mismatch (0 value, 1 address) |
| err_tag | output | 4 | Tag of the first mismatch |
| ovf_value | output | 1 | Sticky overflow of the value queue |
| ovf_addr | output | 1 | Sticky overflow of the address queue |

## Verification
On every cycle the assertions check four things: err_flag and the overflow flags stay set without a clear, the recorded queue and tag stay frozen while the error is held, a cycle with no protected push can neither raise an error nor overflow a queue, and reset clears all flags. Other behaviours depend on what is held inside the queues, so only the bench scenarios can show them. These are pairing across delays and slot combinations in both orders, matching by tag rather than arrival order, the priority among simultaneous mismatches, dropped pushes at capacity, and queues emptied by reset.

// File: rtl/dup_chk_pkg.sv
// Shared constants for the duplicated-instruction result checker.
// Assumes a fixed four-slot issue width; result and tag widths are
// parameters of the modules themselves.
package dup_chk_pkg;
    localparam int NSLOT = 4;

    // Which pairing queue a result belongs to; also the err_queue code.
    typedef enum logic {
        QSEL_VALUE = 1'b0,
        QSEL_ADDR  = 1'b1
    } qsel_e;
endpackage

// File: rtl/dup_slot_split.sv
// Splits the per-slot results into push requests for the value queue and
// the address queue. Only valid, protected results produce a push.
// Assumes the kind bit is meaningful only when the slot is valid.
module dup_slot_split #(
    parameter int NSLOT = 4
) (
    input  logic [NSLOT-1:0] vld,
    input  logic [NSLOT-1:0] dup,
    input  logic [NSLOT-1:0] kind,
    output logic [NSLOT-1:0] push_val,
    output logic [NSLOT-1:0] push_addr
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Route one slot to the queue its kind selects.
        assign push_val[s]  = vld[s] & dup[s] & (kind[s] == dup_chk_pkg::QSEL_VALUE);
        assign push_addr[s] = vld[s] & dup[s] & (kind[s] == dup_chk_pkg::QSEL_ADDR);
    end
endmodule

// File: rtl/dup_pair_queue.sv
// Pairing queue: holds unpaired originals or copies until the partner
// with the same tag and opposite role arrives, then compares the two and
// frees the entry. Pushes are handled in slot-index order within a cycle,
// so same-cycle halves pair with each other. A push that neither pairs nor
// finds a free entry is dropped and reported on ovf.
// Assumes tags of pending pairs are unique per role.
module dup_pair_queue #(
    parameter int NSLOT = 4,
    parameter int DW    = 32,
    parameter int TAGW  = 4,
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      push,
    input  logic [NSLOT-1:0]      copy,
    input  logic [NSLOT*TAGW-1:0] tag,
    input  logic [NSLOT*DW-1:0]   data,
    output logic                  mism,
    output logic [TAGW-1:0]       mism_tag,
    output logic                  ovf
);
    logic [DEPTH-1:0] ent_vld,  nxt_vld;
    logic [DEPTH-1:0] ent_copy, nxt_copy;
    logic [TAGW-1:0]  ent_tag  [DEPTH];
    logic [TAGW-1:0]  nxt_tag  [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [DW-1:0]    nxt_data [DEPTH];

    // Walk the slots in order: pair against held entries, else allocate.
    always_comb begin
        logic hit;
        logic placed;
        logic [TAGW-1:0] stag;
        logic [DW-1:0]   sdat;
        nxt_vld  = ent_vld;
        nxt_copy = ent_copy;
        nxt_tag  = ent_tag;
        nxt_data = ent_data;
        mism     = 1'b0;
        mism_tag = '0;
        ovf      = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            hit    = 1'b0;
            placed = 1'b0;
            stag   = tag[s*TAGW +: TAGW];
            sdat   = data[s*DW +: DW];
            if (push[s]) begin
                for (int e = 0; e < DEPTH; e++) begin
                    if (!hit && nxt_vld[e] && nxt_tag[e] == stag && nxt_copy[e] != copy[s]) begin
                        hit        = 1'b1;
                        nxt_vld[e] = 1'b0;
                        if (nxt_data[e] != sdat && !mism) begin
                            mism     = 1'b1;
                            mism_tag = stag;
                        end
                    end
                end
                if (!hit) begin
                    for (int e = 0; e < DEPTH; e++) begin
                        if (!placed && !nxt_vld[e]) begin
                            placed      = 1'b1;
                            nxt_vld[e]  = 1'b1;
                            nxt_copy[e] = copy[s];
                            nxt_tag[e]  = stag;
                            nxt_data[e] = sdat;
                        end
                    end
                    if (!placed) ovf = 1'b1;
                end
            end
        end
    end

    // Commit the updated entry array; reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_copy <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ent_tag[e]  <= '0;
                ent_data[e] <= '0;
            end
        end else begin
            ent_vld  <= nxt_vld;
            ent_copy <= nxt_copy;
            ent_tag  <= nxt_tag;
            ent_data <= nxt_data;
        end
    end
endmodule

// File: rtl/dup_err_status.sv
// Sticky error and overflow status. Captures queue and tag of the first
// mismatch, with the value queue taking precedence in a tie. A clear
// cycle drops everything but still records a mismatch seen in that cycle.
module dup_err_status #(
    parameter int TAGW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            mism_v,
    input  logic [TAGW-1:0] tag_v,
    input  logic            mism_a,
    input  logic [TAGW-1:0] tag_a,
    input  logic            ovf_v_now,
    input  logic            ovf_a_now,
    output logic            err,
    output logic            err_q,
    output logic [TAGW-1:0] err_tag,
    output logic            ovf_v,
    output logic            ovf_a
);
    logic            any_mism;
    logic            sel_q;
    logic [TAGW-1:0] sel_tag;

    // Pick the mismatch that would be recorded this cycle.
    always_comb begin
        any_mism = mism_v | mism_a;
        sel_q    = mism_v ? dup_chk_pkg::QSEL_VALUE : dup_chk_pkg::QSEL_ADDR;
        sel_tag  = mism_v ? tag_v : tag_a;
    end

    // Hold error, first-failure record and overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err     <= 1'b0;
            err_q   <= 1'b0;
            err_tag <= '0;
            ovf_v   <= 1'b0;
            ovf_a   <= 1'b0;
        end else if (clr) begin
            err     <= any_mism;
            err_q   <= any_mism ? sel_q : 1'b0;
            err_tag <= any_mism ? sel_tag : '0;
            ovf_v   <= ovf_v_now;
            ovf_a   <= ovf_a_now;
        end else begin
            if (!err && any_mism) begin
                err     <= 1'b1;
                err_q   <= sel_q;
                err_tag <= sel_tag;
            end
            ovf_v <= ovf_v | ovf_v_now;
            ovf_a <= ovf_a | ovf_a_now;
        end
    end
endmodule

// File: rtl/dup_result_checker.sv
// Top of the duplicated-instruction result checker. Splits protected slot
// results into a value queue and an address queue, pairs originals with
// copies by tag, and reports mismatches and overflows through sticky flags.
// Assumes the scheduler gives each original and its copy the same tag.
module dup_result_checker #(
    parameter int NSLOT = dup_chk_pkg::NSLOT,
    parameter int DW    = 32,
    parameter int TAGW  = 4,
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      slot_vld,
    input  logic [NSLOT-1:0]      slot_dup,
    input  logic [NSLOT-1:0]      slot_copy,
    input  logic [NSLOT-1:0]      slot_kind,
    input  logic [NSLOT*TAGW-1:0] slot_tag,
    input  logic [NSLOT*DW-1:0]   slot_data,
    input  logic                  clr_err,
    output logic                  err_flag,
    output logic                  err_queue,
    output logic [TAGW-1:0]       err_tag,
    output logic                  ovf_value,
    output logic                  ovf_addr
);
    localparam int NQ = 2;

    logic [NSLOT-1:0] push_q [NQ];
    logic [NQ-1:0]    q_mism;
    logic [TAGW-1:0]  q_tag  [NQ];
    logic [NQ-1:0]    q_ovf;

    dup_slot_split #(.NSLOT(NSLOT)) u_split (
        .vld       (slot_vld),
        .dup       (slot_dup),
        .kind      (slot_kind),
        .push_val  (push_q[0]),
        .push_addr (push_q[1])
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        dup_pair_queue #(.NSLOT(NSLOT), .DW(DW), .TAGW(TAGW), .DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_q[q]),
            .copy     (slot_copy),
            .tag      (slot_tag),
            .data     (slot_data),
            .mism     (q_mism[q]),
            .mism_tag (q_tag[q]),
            .ovf      (q_ovf[q])
        );
    end

    dup_err_status #(.TAGW(TAGW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_err),
        .mism_v    (q_mism[0]),
        .tag_v     (q_tag[0]),
        .mism_a    (q_mism[1]),
        .tag_a     (q_tag[1]),
        .ovf_v_now (q_ovf[0]),
        .ovf_a_now (q_ovf[1]),
        .err       (err_flag),
        .err_q     (err_queue),
        .err_tag   (err_tag),
        .ovf_v     (ovf_value),
        .ovf_a     (ovf_addr)
    );
endmodule

// File: rtl/dup_result_checker_sva.sv
// Property checker for dup_result_checker, attached by bind below.
// Observes top-level ports only.
module dup_result_checker_sva #(
    parameter int NSLOT = 4,
    parameter int TAGW  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] slot_vld,
    input logic [NSLOT-1:0] slot_dup,
    input logic [NSLOT-1:0] slot_kind,
    input logic             clr_err,
    input logic             err_flag,
    input logic             err_queue,
    input logic [TAGW-1:0]  err_tag,
    input logic             ovf_value,
    input logic             ovf_addr
);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag);

    // R7
    err_record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> ($stable(err_tag) && $stable(err_queue)));

    // R5
    no_push_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !clr_err && ((slot_vld & slot_dup) == '0)) |=> !err_flag);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_value || ovf_addr) && !clr_err) |=> ($past(ovf_value) -> ovf_value) && ($past(ovf_addr) -> ovf_addr));

    // R8
    ovf_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_value && ((slot_vld & slot_dup & ~slot_kind) == '0)) |=> !ovf_value);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!err_flag && !ovf_value && !ovf_addr && err_tag == '0));
endmodule

bind dup_result_checker dup_result_checker_sva #(.NSLOT(NSLOT), .TAGW(TAGW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_vld  (slot_vld),
    .slot_dup  (slot_dup),
    .slot_kind (slot_kind),
    .clr_err   (clr_err),
    .err_flag  (err_flag),
    .err_queue (err_queue),
    .err_tag   (err_tag),
    .ovf_value (ovf_value),
    .ovf_addr  (ovf_addr)
);

// File: tb/sim_dup_result_checker.sv
// Self-checking bench: sweeps slot pairs, delays, order and match/mismatch,
// then targeted cases for priority, tag matching, overflow, clear, reset.
module sim_dup_result_checker;
    localparam int NS = 4;
    localparam int DW = 32;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] vld = '0, dup = '0, cpy = '0, knd = '0;
    logic [NS*TW-1:0] tg = '0;
    logic [NS*DW-1:0] dat = '0;
    logic clr = 1'b0;
    logic err_flag, err_queue, ovf_value, ovf_addr;
    logic [TW-1:0] err_tag;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dup_result_checker u0 (
        .clk(clk), .rst_n(rst_n), .slot_vld(vld), .slot_dup(dup),
        .slot_copy(cpy), .slot_kind(knd), .slot_tag(tg), .slot_data(dat),
        .clr_err(clr), .err_flag(err_flag), .err_queue(err_queue),
        .err_tag(err_tag), .ovf_value(ovf_value), .ovf_addr(ovf_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        vld = '0; dup = '0; cpy = '0; knd = '0; tg = '0; dat = '0; clr = 1'b0;
    endtask

    task automatic put(input int s, input logic d, input logic c, input logic k,
                       input logic [TW-1:0] t, input logic [DW-1:0] v);
        vld[s] = 1'b1; dup[s] = d; cpy[s] = c; knd[s] = k;
        tg[s*TW +: TW] = t; dat[s*DW +: DW] = v;
    endtask

    // Apply current inputs across one rising edge, then return to idle.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic clear();
        clr = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int trial;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 err after reset", {31'b0, err_flag}, 0);
        chk("R10 ovf after reset", {30'b0, ovf_value, ovf_addr}, 0);

        // R1 R2 R3 R9: sweep slots, delay, order, match/mismatch
        trial = 0;
        for (int a = 0; a < NS; a++)
            for (int b = 0; b < NS; b++)
                for (int d = 0; d < 3; d++)
                    for (int cf = 0; cf < 2; cf++)
                        for (int m = 0; m < 2; m++) begin
                            logic [TW-1:0] t;
                            logic k;
                            logic [DW-1:0] ov, cv;
                            if (d == 0 && a == b) continue;
                            t  = TW'(trial);
                            k  = 1'((a + b + d) & 1);
                            ov = 32'h1000_0000 + 32'(trial * 37);
                            cv = (m == 1) ? (ov ^ (32'h1 << (trial % 32))) : ov;
                            clear();
                            put(a, 1'b1, 1'(cf), k, t, (cf == 1) ? cv : ov);
                            if (d == 0) begin
                                put(b, 1'b1, 1'(1 - cf), k, t, (cf == 1) ? ov : cv);
                                step();
                            end else begin
                                step();
                                chk("R3 no error while half pending", {31'b0, err_flag}, 0);
                                repeat (d - 1) step();
                                put(b, 1'b1, 1'(1 - cf), k, t, (cf == 1) ? ov : cv);
                                step();
                            end
                            chk("R2 compare result", {31'b0, err_flag}, 32'(m));
                            if (m == 1) begin
                                chk("R1 err_queue selects kind", {31'b0, err_queue}, {31'b0, k});
                                chk("R7 err_tag", {28'b0, err_tag}, {28'b0, t});
                            end
                            trial++;
                        end

        // R1: value and address queues do not pair with each other
        clear();
        put(0, 1'b1, 1'b0, 1'b0, 4'd3, 32'hAAAA);
        put(1, 1'b1, 1'b1, 1'b1, 4'd3, 32'hBBBB);
        step();
        chk("R1 cross-queue halves not compared", {31'b0, err_flag}, 0);
        put(0, 1'b1, 1'b1, 1'b0, 4'd3, 32'hAAAA);
        put(1, 1'b1, 1'b0, 1'b1, 4'd3, 32'hBBBB);
        step();
        chk("R1 each queue pairs its own", {31'b0, err_flag}, 0);

        // R4: pairing by tag, not arrival order
        clear();
        put(0, 1'b1, 1'b0, 1'b0, 4'd1, 32'h111);
        put(2, 1'b1, 1'b0, 1'b0, 4'd2, 32'h222);
        step();
        put(1, 1'b1, 1'b1, 1'b0, 4'd2, 32'h222);
        step();
        put(3, 1'b1, 1'b1, 1'b0, 4'd1, 32'h111);
        step();
        chk("R4 out-of-order tags pair correctly", {31'b0, err_flag}, 0);

        // R5: unmarked result with matching tag and different data is ignored
        clear();
        put(0, 1'b1, 1'b0, 1'b0, 4'd7, 32'h5555);
        step();
        put(1, 1'b0, 1'b1, 1'b0, 4'd7, 32'h6666);
        step();
        chk("R5 unmarked not compared", {31'b0, err_flag}, 0);
        put(2, 1'b1, 1'b1, 1'b0, 4'd7, 32'h5555);
        step();
        chk("R5 original still waiting for real copy", {31'b0, err_flag}, 0);

        // R7 R9: simultaneous mismatches, lowest slot wins within a queue
        clear();
        put(0, 1'b1, 1'b0, 1'b0, 4'd6, 32'h1);
        put(1, 1'b1, 1'b1, 1'b0, 4'd6, 32'h2);
        put(2, 1'b1, 1'b0, 1'b0, 4'd9, 32'h3);
        put(3, 1'b1, 1'b1, 1'b0, 4'd9, 32'h4);
        step();
        chk("R7 lowest slot tag recorded", {28'b0, err_tag}, 6);
        // R7: value queue wins over address queue in the same cycle
        clear();
        put(0, 1'b1, 1'b0, 1'b1, 4'd4, 32'h1);
        put(1, 1'b1, 1'b1, 1'b1, 4'd4, 32'h2);
        put(2, 1'b1, 1'b0, 1'b0, 4'd8, 32'h3);
        put(3, 1'b1, 1'b1, 1'b0, 4'd8, 32'h4);
        step();
        chk("R7 value queue preferred", {31'b0, err_queue}, 0);
        chk("R7 value queue tag", {28'b0, err_tag}, 8);
        // R7: later mismatch does not overwrite the record
        put(0, 1'b1, 1'b0, 1'b1, 4'd5, 32'h9);
        put(1, 1'b1, 1'b1, 1'b1, 4'd5, 32'hA);
        step();
        chk("R7 first record kept queue", {31'b0, err_queue}, 0);
        chk("R7 first record kept tag", {28'b0, err_tag}, 8);

        // R6: sticky, clear drops it, mismatch in clear cycle re-arms
        step();
        chk("R6 error held", {31'b0, err_flag}, 1);
        clear();
        chk("R6 clear drops error", {31'b0, err_flag}, 0);
        put(0, 1'b1, 1'b0, 1'b1, 4'd2, 32'h10);
        step();
        clr = 1'b1;
        put(1, 1'b1, 1'b1, 1'b1, 4'd2, 32'h11);
        step();
        chk("R6 mismatch in clear cycle sets error", {31'b0, err_flag}, 1);
        chk("R6 record from clear cycle", {28'b0, err_tag, 3'b0, err_queue}, 32'h21);

        // R8: capacity 8, ninth dropped with overflow
        clear();
        for (int i = 0; i < 8; i++) begin
            put(0, 1'b1, 1'b0, 1'b0, TW'(i), 32'(i));
            step();
        end
        chk("R8 eight entries fit", {30'b0, ovf_value, ovf_addr}, 0);
        put(0, 1'b1, 1'b0, 1'b0, 4'd8, 32'h8);
        step();
        chk("R8 ninth overflows value queue", {30'b0, ovf_value, ovf_addr}, 2);
        put(1, 1'b1, 1'b1, 1'b0, 4'd0, 32'h0);
        step();
        put(1, 1'b1, 1'b1, 1'b0, 4'd8, 32'hDEAD);
        step();
        chk("R8 dropped entry not compared", {31'b0, err_flag}, 0);
        chk("R8 overflow sticky", {31'b0, ovf_value}, 1);
        clear();
        chk("R8 clear drops overflow", {31'b0, ovf_value}, 0);

        // R10: reset empties queues
        put(0, 1'b1, 1'b0, 1'b0, 4'd5, 32'hCAFE);
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        put(1, 1'b1, 1'b1, 1'b0, 4'd5, 32'hBEEF);
        step();
        chk("R10 held entry gone after reset", {31'b0, err_flag}, 0);
        put(2, 1'b1, 1'b0, 1'b0, 4'd5, 32'hBEEF);
        step();
        chk("R10 fresh pairing after reset", {31'b0, err_flag}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule